// File: doc/BRIEF.md
# Power-Up Clock Source Selector

This block decides, once after reset, whether a fast enough clock is toggling on the shared external clock pin. A driven clock and the output of a crystal oscillator reach the pin through the same path and are judged the same way. Until the decision is made, the converter core runs from the free-running internal oscillator. The block counts rising edges of the pin clock over fixed windows, each timed by the internal oscillator. It selects the pin clock only when the rate is above the minimum frequency in every one of a number of back-to-back windows.

When the pin clock wins, a glitch-free multiplexer hands the core over to it. The internal oscillator enable is dropped only after the hand-over has been acknowledged. The choice then holds until the next reset, and later activity on the pin has no effect.

The defaults assume a 4915 kHz oscillator and a 300 kHz minimum rate. The measurement window is 1024 oscillator cycles, so the edge threshold is 62. A window counts as "above" when it contains 63 or more edges.

Top module: `clk_src_detect`

## Requirements
- R1: While `rst_n` is low and until a decision is made, `osc_en`=1, `sel_done`=0, `ext_sel`=0, and `clk_out` follows `osc_clk`.
- R2: A window counts as above the threshold when more than EDGE_THR = MIN_EXT_KHZ*WIN_CYC/OSC_KHZ synchronised rising edges of `ext_clk` fall within it (62 with the defaults). An `ext_clk` with a period of 18 oscillator cycles (56 edges) is rejected.
- R3: If the first window is not above the threshold (including a pin held at 0), then on the WIN_CYC-th `osc_clk` rising edge after reset `sel_done` becomes 1, with `ext_sel`=0 and `osc_en`=1.
- R4: The external clock is chosen only after CONFIRM (default 2) consecutive windows above the threshold. Any window below the threshold before that ends the decision as internal, at the end of that window.
- R5: After CONFIRM windows above the threshold, within 48 oscillator cycles `sel_done`=1, `ext_sel`=1, `osc_en`=0, and `clk_out` follows `ext_clk`.
- R6: `osc_en` falls only after the external path of the output multiplexer is enabled and that enable has been acknowledged in the oscillator domain.
- R7: The switch is glitch-free. The two source enables are never high together, and `clk_out` has no high or low phase shorter than the shorter half period of the two sources.
- R8: Once `sel_done` is 1, it and `ext_sel` hold until reset. Later changes of rate on `ext_clk` have no effect on the outputs.
- R9: `ext_clk` passes through a synchroniser of at least two flops and an edge detector, giving one single-cycle pulse per rising edge. A 16-cycle period therefore yields 64 counted edges per default window.
- R10: A reset taken during measurement discards the partial result, and a fresh decision follows the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running internal oscillator clock; times the measurement |
| ext_clk | input | 1 | Clock from the shared external pin (driven clock or crystal oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset; starts a new decision |
| osc_en | output | 1 | Enable for the internal oscillator; low once the external clock drives the core |
| clk_out | output | 1 | Glitch-free selected clock for the converter core |
| ext_sel | output | 1 | 1 when the external clock has been selected |
| sel_done | output | 1 | 1 once the selection is complete, until reset |

## Verification
The hardest situation to reach is a window above the threshold followed by one below it. This must abort the confirmation and leave the internal clock selected. The bench drives a fast pin clock for the first window plus a margin of 100 cycles, then grounds the pin, so the second window falls below the threshold. The reference model counts the pin edges per window on its own.

A second hard case is a reset taken in the middle of a measurement. The bench asserts reset part-way through a run and checks that a fresh decision follows. A real-time monitor on `clk_out` catches any runt phase during the hand-over.

// File: rtl/cksel_pkg.sv
package cksel_pkg;

   typedef enum logic [1:0] {
      ST_MEAS   = 2'd0,
      ST_SWITCH = 2'd1,
      ST_INT    = 2'd2,
      ST_EXT    = 2'd3
   } sel_state_e;

   function automatic int min_edges(input int win_cyc, input int osc_khz, input int min_khz);
      return (min_khz * win_cyc) / osc_khz;
   endfunction

endpackage

// File: rtl/ck_edge_sync.sv
module ck_edge_sync #(
   parameter int STAGES    = 2,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("ck_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[LAST-1:0], async_in};
   end

   if (RISE_EDGE) begin : g_rise
      assign pulse = chain[LAST-1] & ~chain[LAST];
   end else begin : g_fall
      assign pulse = ~chain[LAST-1] & chain[LAST];
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R9

endmodule

// File: rtl/ck_rate_window.sv
module ck_rate_window #(
   parameter int WIN_CYC  = 1024,
   parameter int EDGE_THR = 62
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic edge_pulse,
   output logic win_end,
   output logic above
);
   localparam int WCW = $clog2(WIN_CYC);
   localparam int ECW = $clog2(WIN_CYC + 2);
   localparam logic [WCW-1:0] W_LAST = WCW'(WIN_CYC - 1);
   localparam logic [WCW-1:0] W_ONE  = WCW'(1);
   localparam logic [ECW-1:0] E_ONE  = ECW'(1);
   localparam logic [ECW:0]   THR_W  = (ECW+1)'(EDGE_THR);

   logic [WCW-1:0] wcnt;
   logic [ECW-1:0] ecnt;
   logic [ECW:0]   ecnt_tot;

   if (WIN_CYC < 8) begin : g_bad_win
      $error("ck_rate_window: WIN_CYC too small");
   end
   if (EDGE_THR >= WIN_CYC / 2) begin : g_bad_thr
      $error("ck_rate_window: EDGE_THR unreachable in one window");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         ecnt <= '0;
      end else if (!run) begin
         wcnt <= '0;
         ecnt <= '0;
      end else if (wcnt == W_LAST) begin
         wcnt <= '0;
         ecnt <= edge_pulse ? E_ONE : '0;
      end else begin
         wcnt <= wcnt + W_ONE;
         if (edge_pulse) ecnt <= ecnt + E_ONE;
      end
   end

   assign ecnt_tot = {1'b0, ecnt} + {{ECW{1'b0}}, edge_pulse};
   assign win_end  = run && (wcnt == W_LAST);
   assign above    = ecnt_tot > THR_W;

   AST_WIN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> !win_end); // R2
   AST_ECNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ecnt <= ECW'(WIN_CYC / 2 + 1)); // R9

endmodule

// File: rtl/ck_glitchless_mux.sv
module ck_glitchless_mux #(
   parameter int ACK_STAGES = 2
) (
   input  logic a_clk,
   input  logic b_clk,
   input  logic rst_n,
   input  logic sel_b,
   output logic out_clk,
   output logic b_ack
);
   logic a_q1, a_en;
   logic b_q1, b_en;
   logic [ACK_STAGES-1:0] ack_sh;

   if (ACK_STAGES < 2) begin : g_bad_ack
      $error("ck_glitchless_mux: ACK_STAGES must be at least 2");
   end

   // source A side: released only while B is neither requested nor enabled
   always_ff @(posedge a_clk or negedge rst_n) begin
      if (!rst_n) a_q1 <= 1'b1;
      else        a_q1 <= ~sel_b & ~b_en;
   end
   always_ff @(negedge a_clk or negedge rst_n) begin
      if (!rst_n) a_en <= 1'b1;
      else        a_en <= a_q1;
   end

   // source B side: waits until A has gated itself off on its own low phase
   always_ff @(posedge b_clk or negedge rst_n) begin
      if (!rst_n) b_q1 <= 1'b0;
      else        b_q1 <= sel_b & ~a_en;
   end
   always_ff @(negedge b_clk or negedge rst_n) begin
      if (!rst_n) b_en <= 1'b0;
      else        b_en <= b_q1;
   end

   // acknowledge of the B enable back into the A domain
   always_ff @(posedge a_clk or negedge rst_n) begin
      if (!rst_n) ack_sh <= '0;
      else        ack_sh <= {ack_sh[ACK_STAGES-2:0], b_en};
   end

   assign b_ack   = ack_sh[ACK_STAGES-1];
   assign out_clk = (a_clk & a_en) | (b_clk & b_en);

   always_comb begin
      if (rst_n) begin
         AST_ONE_SOURCE: assert (!(a_en && b_en)); // R7
      end
   end

endmodule

// File: rtl/clk_src_detect.sv
module clk_src_detect
   import cksel_pkg::*;
#(
   parameter int OSC_KHZ     = 4915,
   parameter int MIN_EXT_KHZ = 300,
   parameter int WIN_CYC     = 1024,
   parameter int CONFIRM     = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic ext_clk,
   input  logic rst_n,
   output logic osc_en,
   output logic clk_out,
   output logic ext_sel,
   output logic sel_done
);
   localparam int EDGE_THR = min_edges(WIN_CYC, OSC_KHZ, MIN_EXT_KHZ);
   localparam int HW       = $clog2(CONFIRM + 1);
   localparam logic [HW-1:0] H_LAST = HW'(CONFIRM - 1);
   localparam logic [HW-1:0] H_ONE  = HW'(1);

   if (CONFIRM < 1) begin : g_bad_confirm
      $error("clk_src_detect: CONFIRM must be at least 1");
   end
   if (MIN_EXT_KHZ >= OSC_KHZ / 2) begin : g_bad_rate
      $error("clk_src_detect: threshold not measurable with this oscillator");
   end

   sel_state_e state;
   logic [HW-1:0] hits;
   logic ext_edge, win_end, above, ext_ack, go_ext, run;

   ck_edge_sync #(.STAGES(SYNC_STAGES), .RISE_EDGE(1'b1)) u_sync (
      .clk(osc_clk), .rst_n(rst_n), .async_in(ext_clk), .pulse(ext_edge));

   assign run = (state == ST_MEAS);

   ck_rate_window #(.WIN_CYC(WIN_CYC), .EDGE_THR(EDGE_THR)) u_win (
      .clk(osc_clk), .rst_n(rst_n), .run(run), .edge_pulse(ext_edge),
      .win_end(win_end), .above(above));

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_MEAS;
         hits  <= '0;
      end else begin
         unique case (state)
            ST_MEAS: if (win_end) begin
               if (!above)              state <= ST_INT;
               else if (hits == H_LAST) state <= ST_SWITCH;
               else                     hits  <= hits + H_ONE;
            end
            ST_SWITCH: if (ext_ack) state <= ST_EXT;
            default: ;
         endcase
      end
   end

   assign go_ext = (state == ST_SWITCH) || (state == ST_EXT);

   ck_glitchless_mux #(.ACK_STAGES(2)) u_mux (
      .a_clk(osc_clk), .b_clk(ext_clk), .rst_n(rst_n), .sel_b(go_ext),
      .out_clk(clk_out), .b_ack(ext_ack));

   assign sel_done = (state == ST_INT) || (state == ST_EXT);
   assign ext_sel  = (state == ST_EXT);
   assign osc_en   = (state != ST_EXT);

   AST_DONE_STICKY: assert property (@(posedge osc_clk) disable iff (!rst_n)
      sel_done |=> sel_done); // R8
   AST_SEL_HOLD: assert property (@(posedge osc_clk) disable iff (!rst_n)
      sel_done |=> $stable(ext_sel)); // R8
   AST_OSC_OFF_AFTER_ACK: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !osc_en |-> ext_ack); // R6
   AST_INT_AT_WINDOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
      ($rose(sel_done) && !ext_sel) |-> $past(win_end)); // R3

endmodule

// File: tb/clk_src_detect_test.sv
module clk_src_detect_test;
   localparam int W      = 1024;
   localparam int THR    = 62;
   localparam int CONF   = 2;
   localparam int SW_LIM = 48;

   logic osc_clk = 1'b0;
   logic ext_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic osc_en, clk_out, ext_sel, sel_done;

   int checks = 0;
   int errors = 0;
   int ext_half = 0;
   int ph = 0;

   clk_src_detect uut (
      .osc_clk(osc_clk), .ext_clk(ext_clk), .rst_n(rst_n),
      .osc_en(osc_en), .clk_out(clk_out), .ext_sel(ext_sel), .sel_done(sel_done));

   always #5 osc_clk = ~osc_clk;

   // pin clock generator: toggles on oscillator falling edges, half period ext_half cycles
   always @(negedge osc_clk) begin
      if (ext_half == 0) begin
         ext_clk <= 1'b0;
         ph <= 0;
      end else if (ph + 1 >= ext_half) begin
         ph <= 0;
         ext_clk <= ~ext_clk;
      end else begin
         ph <= ph + 1;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int   cyc, m_edges, m_hits, m_state, m_t;
   logic prev_ext;

   always @(posedge osc_clk) begin
      if (!rst_n) begin
         cyc = 0; m_edges = 0; m_hits = 0; m_state = 0; m_t = 0;
         prev_ext = ext_clk;
      end else begin
         cyc++;
         if (ext_clk && !prev_ext) m_edges++;
         prev_ext = ext_clk;
         if (m_state == 0 && (cyc % W) == 0) begin
            if (m_edges > THR) begin
               m_hits++;
               if (m_hits == CONF) begin m_state = 2; m_t = cyc; end
            end else begin
               m_state = 1; m_t = cyc;
            end
            m_edges = 0;
         end
         #2;
         if (m_state == 0) begin
            chk("R1", sel_done, 1'b0, "sel_done pending");
            chk("R1", osc_en, 1'b1, "osc_en pending");
            chk("R4", ext_sel, 1'b0, "ext_sel pending");
            chk("R1", clk_out, osc_clk, "clk_out pending");
         end else if (m_state == 1) begin
            chk("R3", sel_done, 1'b1, "sel_done internal");
            chk("R8", ext_sel, 1'b0, "ext_sel internal");
            chk("R3", osc_en, 1'b1, "osc_en internal");
            chk("R3", clk_out, osc_clk, "clk_out internal");
         end else if (cyc == m_t) begin
            chk("R6", osc_en, 1'b1, "osc_en at confirm");
         end else if (cyc >= m_t + SW_LIM) begin
            chk("R5", sel_done, 1'b1, "sel_done external");
            chk("R8", ext_sel, 1'b1, "ext_sel external");
            chk("R5", osc_en, 1'b0, "osc_en external");
            chk("R5", clk_out, ext_clk, "clk_out external");
         end
      end
   end

   // runt-pulse monitor on the selected clock
   realtime last_t = -1.0;
   always @(clk_out) begin
      if (!rst_n) last_t = -1.0;
      else begin
         if (last_t >= 0.0 && ($realtime - last_t) < 4.0) begin
            checks++; errors++;
            $display("FAIL R7 clk_out phase actual=%0t expected>=4ns", $realtime - last_t);
         end
         last_t = $realtime;
      end
   end

   task automatic do_reset();
      @(negedge osc_clk) rst_n = 1'b0;
      repeat (3) @(posedge osc_clk);
      #2;
      chk("R1", osc_en, 1'b1, "osc_en in reset");
      chk("R1", sel_done, 1'b0, "sel_done in reset");
      chk("R1", ext_sel, 1'b0, "ext_sel in reset");
      @(negedge osc_clk) rst_n = 1'b1;
   endtask

   task automatic scen(input int half, input int cycles);
      ext_half = half;
      do_reset();
      repeat (cycles) @(posedge osc_clk);
   endtask

   initial begin
      // R3: pin grounded
      scen(0, 2500);
      // R9 R5: period 16 gives 64 edges per window; then R8 pin slows, no effect
      scen(8, 2200);
      ext_half = 9;
      repeat (800) @(posedge osc_clk);
      // R2: period 18 rejected
      scen(9, 2500);
      // R4: one window above, then pin grounded
      scen(8, W + 100);
      ext_half = 0;
      repeat (1500) @(posedge osc_clk);
      // R8: internal chosen, pin starts later
      scen(0, 1500);
      ext_half = 8;
      repeat (2000) @(posedge osc_clk);
      // R10: reset in the middle of measurement, then fresh decision
      scen(8, 1500);
      scen(8, 2500);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(100000 * 10);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule